// File: doc/BRIEF.md
# Display-Register Address Couple Resolver

This block turns a 14-bit address couple into an absolute memory word address. A bank of display registers holds one frame base address per lexical level. The couple is split into a level selector at the top and a word index below it. Where the split falls depends on the lexical level of the code that is running. The selected base plus the index gives the address.

Each level also keeps a frame bound. An index that reaches the bound raises a bound trap and produces no address. A selector that names a level deeper than the running code raises a level trap. The procedure entry and exit logic loads a level's base and bound through a separate update port. The result is registered, so it appears one cycle after the request.

Top module: `couple_resolver`

## Requirements
- R1: After reset, `vld_o`, `trap_level_o`, `trap_bound_o` and `addr_o` are 0. Every level's base and bound are 0, so the first resolve of couple 0 at current level 0 reports a bound trap.
- R2: The width of the level selector follows the current level. Levels 0–1 use 1 bit (bit 13), 2–3 use 2 bits (13:12), 4–7 use 3 bits (13:11), 8–15 use 4 bits (13:10) and 16–31 use 5 bits (13:9). The remaining low bits are the index.
- R3: On an accepted resolve, `addr_o` equals the selected level's base plus the index, modulo 2^ADDR_W.
- R4: An index greater than or equal to the selected level's bound sets `trap_bound_o` and forces `addr_o` to 0. An index of bound-1 resolves normally.
- R5: A selector greater than the current level sets `trap_level_o` and forces `addr_o` to 0. In that case `trap_bound_o` stays 0, and at most one trap flag is ever high.
- R6: The outputs for a request sampled at a clock edge appear after that edge. `vld_o` is high for exactly one cycle per request cycle. With no request, `vld_o`, both traps and `addr_o` are 0.
- R7: A base and bound write is visible to resolves from the next cycle. A resolve in the same cycle as the write uses the old values.
- R8: A write to one level leaves every other level's base and bound unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cur_lvl_i | input | 5 | Lexical level of the running code |
| req_i | input | 1 | Resolve request |
| couple_i | input | 14 | Address couple to resolve |
| upd_i | input | 1 | Display register write strobe |
| upd_lvl_i | input | 5 | Level being written |
| upd_base_i | input | ADDR_W | New frame base |
| upd_bound_i | input | 14 | New frame bound in words |
| vld_o | output | 1 | Result valid |
| addr_o | output | ADDR_W | Resolved word address, 0 on a trap |
| trap_level_o | output | 1 | Selector is above the current level |
| trap_bound_o | output | 1 | Index is outside the frame |

## Verification
The hardest case to reach is a write and a resolve of the same level in the same cycle. The ordering rule only shows when both strobes are high on one edge. The bench raises the update and request strobes on the same falling edge, so the captured address must carry the old base. It then resolves again and expects the new base. The vector table is set up so that each split width has a pass case and a trap case, with the bound-1 and bound indices placed at the point where the split moves.

// File: rtl/couple_res_pkg.sv
package couple_res_pkg;
  localparam int unsigned LVL_W   = 5;
  localparam int unsigned NUM_LVL = 1 << LVL_W;
  localparam int unsigned CPL_W   = 14;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [CPL_W-1:0] cpl_t;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_BOUND = 2'd1,
    RES_LEVEL = 2'd2
  } res_kind_e;
endpackage

// File: rtl/couple_split.sv
module couple_split
  import couple_res_pkg::*;
(
  input  lvl_t cur_lvl_i,
  input  cpl_t couple_i,
  output lvl_t sel_lvl_o,
  output cpl_t idx_o
);
  int unsigned sel_w;
  cpl_t        sel_raw;
  cpl_t        idx_mask;

  // selector width = position of highest set bit of current level + 1, min 1
  always_comb begin
    sel_w = 1;
    for (int unsigned b = 1; b < LVL_W; b++) begin
      if (cur_lvl_i[b]) sel_w = b + 1;
    end
    sel_raw  = couple_i >> (CPL_W - sel_w);
    idx_mask = ~(cpl_t'('1) << (CPL_W - sel_w));
  end

  assign sel_lvl_o = sel_raw[LVL_W-1:0];
  assign idx_o     = couple_i & idx_mask;
endmodule

// File: rtl/display_bank.sv
module display_bank
  import couple_res_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned BOUND_W = CPL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  lvl_t               wr_lvl_i,
  input  logic [ADDR_W-1:0]  wr_base_i,
  input  logic [BOUND_W-1:0] wr_bound_i,
  input  lvl_t               rd_lvl_i,
  output logic [ADDR_W-1:0]  rd_base_o,
  output logic [BOUND_W-1:0] rd_bound_o
);
  logic [ADDR_W-1:0]  base_q  [NUM_LVL];
  logic [BOUND_W-1:0] bound_q [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
      end else if (we_i && wr_lvl_i == lvl_t'(g)) begin
        base_q[g]  <= wr_base_i;
        bound_q[g] <= wr_bound_i;
      end
    end
  end

  assign rd_base_o  = base_q[rd_lvl_i];
  assign rd_bound_o = bound_q[rd_lvl_i];
endmodule

// File: rtl/couple_resolver.sv
module couple_resolver
  import couple_res_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        cur_lvl_i,
  input  logic              req_i,
  input  logic [13:0]       couple_i,
  input  logic              upd_i,
  input  logic [4:0]        upd_lvl_i,
  input  logic [ADDR_W-1:0] upd_base_i,
  input  logic [13:0]       upd_bound_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              trap_level_o,
  output logic              trap_bound_o
);
  lvl_t              sel_lvl;
  cpl_t              idx;
  logic [ADDR_W-1:0] base;
  cpl_t              bound;
  res_kind_e         kind;
  logic [ADDR_W-1:0] sum;

  couple_split i_split (
    .cur_lvl_i (cur_lvl_i),
    .couple_i  (couple_i),
    .sel_lvl_o (sel_lvl),
    .idx_o     (idx)
  );

  display_bank #(.ADDR_W(ADDR_W), .BOUND_W(CPL_W)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (upd_i),
    .wr_lvl_i   (upd_lvl_i),
    .wr_base_i  (upd_base_i),
    .wr_bound_i (upd_bound_i),
    .rd_lvl_i   (sel_lvl),
    .rd_base_o  (base),
    .rd_bound_o (bound)
  );

  // level check wins: bound of an unreachable level is meaningless
  always_comb begin
    sum = base + ADDR_W'(idx);
    if (sel_lvl > cur_lvl_i) kind = RES_LEVEL;
    else if (idx >= bound)   kind = RES_BOUND;
    else                     kind = RES_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      addr_o       <= '0;
      trap_level_o <= 1'b0;
      trap_bound_o <= 1'b0;
    end else begin
      vld_o        <= req_i;
      trap_level_o <= req_i && kind == RES_LEVEL;
      trap_bound_o <= req_i && kind == RES_BOUND;
      addr_o       <= (req_i && kind == RES_OK) ? sum : '0;
    end
  end
endmodule

module couple_resolver_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        cur_lvl_i,
  input logic              req_i,
  input logic [13:0]       couple_i,
  input logic              vld_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              trap_level_o,
  input logic              trap_bound_o
);
  assert_vld_follows_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(req_i));

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> (!trap_level_o && !trap_bound_o && addr_o == '0));

  assert_trap_no_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_bound_o || trap_level_o) |-> addr_o == '0);

  assert_one_trap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trap_level_o, trap_bound_o}));

  assert_lvl0_upper_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cur_lvl_i == 5'd0 && couple_i[13]) |=> trap_level_o);

  assert_top_lvl_no_level_trap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && cur_lvl_i == 5'd31) |=> !trap_level_o);
endmodule

bind couple_resolver couple_resolver_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cur_lvl_i    (cur_lvl_i),
  .req_i        (req_i),
  .couple_i     (couple_i),
  .vld_o        (vld_o),
  .addr_o       (addr_o),
  .trap_level_o (trap_level_o),
  .trap_bound_o (trap_bound_o)
);

// File: tb/test_couple_resolver.sv
module test_couple_resolver;
  localparam int ADDR_W = 20;
  localparam int NV     = 14;
  // {cur, couple, kind(0 ok,1 bound,2 level), addr}
  localparam logic [40:0] VEC [NV] = '{
    {5'd0,  14'h0005, 2'd0, 20'd12},
    {5'd1,  14'h200A, 2'd0, 20'd1041},
    {5'd0,  14'h2000, 2'd2, 20'd0},
    {5'd3,  14'h3064, 2'd0, 20'd3179},
    {5'd2,  14'h3064, 2'd2, 20'd0},
    {5'd7,  14'h28F9, 2'd0, 20'd5376},
    {5'd7,  14'h28FA, 2'd1, 20'd0},
    {5'd15, 14'h3000, 2'd0, 20'd12295},
    {5'd16, 14'h21FF, 2'd1, 20'd0},
    {5'd31, 14'h3F2C, 2'd0, 20'd32051},
    {5'd20, 14'h3200, 2'd2, 20'd0},
    {5'd8,  14'h2117, 2'd0, 20'd8478},
    {5'd8,  14'h3000, 2'd2, 20'd0},
    {5'd0,  14'h3FFF, 2'd2, 20'd0}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [4:0]        cur_lvl_i = '0;
  logic              req_i = 1'b0;
  logic [13:0]       couple_i = '0;
  logic              upd_i = 1'b0;
  logic [4:0]        upd_lvl_i = '0;
  logic [ADDR_W-1:0] upd_base_i = '0;
  logic [13:0]       upd_bound_i = '0;
  logic              vld_o, trap_level_o, trap_bound_o;
  logic [ADDR_W-1:0] addr_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  couple_resolver #(.ADDR_W(ADDR_W)) i_couple_resolver (
    .clk_i, .rst_ni, .cur_lvl_i, .req_i, .couple_i,
    .upd_i, .upd_lvl_i, .upd_base_i, .upd_bound_i,
    .vld_o, .addr_o, .trap_level_o, .trap_bound_o
  );

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic write_lvl(input int lvl, input int base, input int bound);
    @(negedge clk_i);
    upd_i = 1'b1; upd_lvl_i = 5'(lvl);
    upd_base_i = ADDR_W'(base); upd_bound_i = 14'(bound);
    @(negedge clk_i);
    upd_i = 1'b0;
  endtask

  // kind: 0 ok, 1 bound, 2 level
  task automatic resolve(input string tag, input int cur, input int cpl,
                         input int kind, input int addr);
    @(negedge clk_i);
    cur_lvl_i = 5'(cur); couple_i = 14'(cpl); req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check({tag, " vld"}, int'(vld_o), 1);
    check({tag, " kind"}, int'({trap_level_o, trap_bound_o}), kind);
    check({tag, " addr"}, int'(addr_o), addr);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 vld", int'(vld_o), 0);
    check("R1 traps", int'({trap_level_o, trap_bound_o}), 0);
    check("R1 addr", int'(addr_o), 0);
    rst_ni = 1'b1;
    resolve("R1 zero bound", 0, 0, 1, 0);

    for (int l = 0; l < 32; l++) write_lvl(l, l * 1024 + 7, 200 + 10 * l);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      resolve($sformatf("R2/R3/R4/R5 vec%0d", i), int'(VEC[i][40:36]),
              int'(VEC[i][35:22]), int'(VEC[i][21:20]), int'(VEC[i][19:0]));
    end

    // R6 idle cycle after a request
    @(negedge clk_i);
    check("R6 idle vld", int'(vld_o), 0);
    check("R6 idle addr", int'(addr_o), 0);

    // R7 write and resolve of level 4 in the same cycle
    @(negedge clk_i);
    upd_i = 1'b1; upd_lvl_i = 5'd4; upd_base_i = 20'd50000; upd_bound_i = 14'd240;
    cur_lvl_i = 5'd4; couple_i = 14'h2000; req_i = 1'b1;
    @(negedge clk_i);
    upd_i = 1'b0; req_i = 1'b0;
    check("R7 same-cycle old base", int'(addr_o), 4 * 1024 + 7);
    resolve("R7 new base", 4, 'h2000, 0, 50000);
    // R8 neighbour level untouched
    resolve("R8 level3 kept", 4, 6145, 0, 3080);
    resolve("R8 level5 kept", 7, 'h28F9, 0, 5376);

    // R3 wrap modulo 2^ADDR_W
    write_lvl(6, (1 << ADDR_W) - 2, 100);
    resolve("R3 wrap", 7, 12293, 0, 3);
    // R4 bound of zero traps index 0
    write_lvl(2, 500, 0);
    resolve("R4 zero bound", 3, 'h2000, 1, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule